// File: doc/BRIEF.md
# Profile-Driven Waveform RAM Sequencer

This block plays back a waveform from a 1024-word, 32-bit memory. Eight profile slots set how playback runs. Each slot holds an address window (first and last address), a step-rate divider, a 3-bit sequencing mode and two option bits: no-dwell and zero-crossing gating. A profile selector picks the slot that drives an address counter. The counter steps through the window at the divided rate, following the chosen mode. The word at the current address is sent downstream, together with a 2-bit code that says which synthesis parameter the word modulates.

Software fills the memory through a synchronous write port and programs the slots through a second write port. After that, playback is steered only by the profile selector and the direction input. When zero-crossing gating is enabled on the active direct-switch slot, a profile change waits for an edge on the phase accumulator's top bit. Without gating, it happens on the next clock.

Top module: `wram_seq`

## Requirements
- R1: One clock after the counter holds address A, `word_out` equals the word last written to A through `ram_we`/`ram_waddr`/`ram_wdata`.
- R2: `dest_out` equals `dest_cfg` one clock later. Codes are 00 frequency, 01 phase, 10 amplitude, 11 polar.
- R3: A profile change is accepted when `prof_sel` differs from `act_prof` and no gate applies. The clock edge that accepts it sets `act_prof` to `prof_sel` and loads `rd_addr` with that slot's first address. The same edge restarts the step divider.
- R4: Outside direct mode, n clocks after a reload the counter has taken floor(n / max(rate,1)) steps. A rate of 0 behaves as 1.
- R5: Mode 000 (direct switch): `rd_addr` stays at the slot's first address on every clock.
- R6: Mode 001 (ramp-up) with no-dwell clear: the counter rises by one per step until it reaches the last address, then holds there.
- R7: Mode 001 with no-dwell set: after the last address, the next step returns the counter to the first address, and it stays there.
- R8: Mode 010 (bidirectional): while `dir_up` is 1 the counter steps up toward the last address; while it is 0 it steps down toward the first. It holds when it reaches either end.
- R9: Mode 011 (bidirectional continuous): the counter runs a triangle, first to last and back, turning at each end on the step that reaches it. It never stops.
- R10: Mode 100 (ramp-up continuous): after the last address the next step wraps the counter to the first address, and it keeps going.
- R11: While the active slot is in mode 000 with zero-crossing set, a pending profile change is held back. It is accepted only on a clock where `acc_msb` differs from its value on the previous clock.
- R12: During reset, `rd_addr`, `act_prof`, `word_out` and `dest_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_we | input | 1 | Waveform memory write strobe |
| ram_waddr | input | ADDR_W | Waveform memory write address |
| ram_wdata | input | DATA_W | Waveform memory write data |
| cfg_we | input | 1 | Profile slot write strobe |
| cfg_idx | input | SEL_W | Profile slot being written |
| cfg_rate | input | RATE_W | Step-rate divider (0 acts as 1) |
| cfg_start | input | ADDR_W | First address of the window |
| cfg_end | input | ADDR_W | Last address of the window |
| cfg_mode | input | 3 | Sequencing mode |
| cfg_nodwell | input | 1 | Return to first address after the last (ramp-up) |
| cfg_zc | input | 1 | Zero-crossing gated switching (direct switch) |
| prof_sel | input | SEL_W | Requested profile |
| dir_up | input | 1 | Direction in bidirectional mode |
| acc_msb | input | 1 | Phase accumulator top bit |
| dest_cfg | input | 2 | Destination code of the played words |
| rd_addr | output | ADDR_W | Current playback address |
| word_out | output | DATA_W | Memory word at the previous clock's address |
| dest_out | output | 2 | Registered destination code |
| act_prof | output | SEL_W | Profile currently in effect |

## Verification
A faulty address counter or divider shows up on `rd_addr` within one step period. The wrong word then appears on `word_out` one clock later. Every address is checked against a value the bench computes from the window and the rate. Each address of the memory is reached once through direct switching, so a bad memory write or read, or a bad profile reload, fails on the very access that hits it. An error in the direction flag, the stop flag or the zero-crossing edge detector changes the turning point, the resting address or the clock on which `act_prof` moves. That clock is checked in every sequencing mode and for both edge polarities.

// File: rtl/wram_pkg.sv
package wram_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      SEQ_DIRECT     = 3'b000,
      SEQ_RAMP       = 3'b001,
      SEQ_BIDIR      = 3'b010,
      SEQ_BIDIR_CONT = 3'b011,
      SEQ_RAMP_CONT  = 3'b100
   } seq_mode_e;

   typedef enum logic [1:0] {
      DST_FREQ  = 2'b00,
      DST_PHASE = 2'b01,
      DST_AMPL  = 2'b10,
      DST_POLAR = 2'b11
   } dest_e;

endpackage

// File: rtl/wram_store.sv
module wram_store #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= mem[raddr];
   end

endmodule

// File: rtl/wram_prof_bank.sv
module wram_prof_bank
   import wram_pkg::*;
#(
   parameter int N_PROF = 8,
   parameter int ADDR_W = 10,
   parameter int RATE_W = 16,
   localparam int SEL_W  = (N_PROF > 1) ? $clog2(N_PROF) : 1,
   localparam int F_ZC   = MODE_W,
   localparam int F_ND   = MODE_W + 1,
   localparam int F_BEG  = MODE_W + 2,
   localparam int F_END  = F_BEG + ADDR_W,
   localparam int F_RATE = F_END + ADDR_W,
   localparam int PROF_W = F_RATE + RATE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [SEL_W-1:0]  widx,
   input  logic [RATE_W-1:0] w_rate,
   input  logic [ADDR_W-1:0] w_start,
   input  logic [ADDR_W-1:0] w_end,
   input  logic [MODE_W-1:0] w_mode,
   input  logic              w_nodwell,
   input  logic              w_zc,
   input  logic [SEL_W-1:0]  act_idx,
   input  logic [SEL_W-1:0]  req_idx,
   output logic [RATE_W-1:0] act_rate,
   output logic [ADDR_W-1:0] act_start,
   output logic [ADDR_W-1:0] act_end,
   output logic [MODE_W-1:0] act_mode,
   output logic              act_nodwell,
   output logic              act_zc,
   output logic [ADDR_W-1:0] req_start
);

   logic [PROF_W-1:0] slot [N_PROF];
   logic [PROF_W-1:0] wword;
   logic [PROF_W-1:0] aword;
   logic [PROF_W-1:0] rword;

   assign wword = {w_rate, w_end, w_start, w_nodwell, w_zc, w_mode};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_PROF; i++) slot[i] <= '0;
      end else if (we) begin
         for (int i = 0; i < N_PROF; i++)
            if (widx == SEL_W'(i)) slot[i] <= wword;
      end
   end

   assign aword = slot[act_idx];
   assign rword = slot[req_idx];

   assign act_mode    = aword[MODE_W-1:0];
   assign act_zc      = aword[F_ZC];
   assign act_nodwell = aword[F_ND];
   assign act_start   = aword[F_END-1:F_BEG];
   assign act_end     = aword[F_RATE-1:F_END];
   assign act_rate    = aword[PROF_W-1:F_RATE];
   assign req_start   = rword[F_END-1:F_BEG];

endmodule

// File: rtl/wram_rate.sv
module wram_rate #(
   parameter int RATE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [RATE_W-1:0] rate,
   output logic              tick
);

   logic [RATE_W-1:0] cnt;
   logic [RATE_W-1:0] lim;

   // A zero divider is treated as a divide-by-one.
   assign lim  = (rate == '0) ? '0 : rate - 1'b1;
   assign tick = (cnt >= lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (restart) cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/wram_addr_seq.sv
module wram_addr_seq
   import wram_pkg::*;
#(
   parameter int N_PROF    = 8,
   parameter int ADDR_W    = 10,
   parameter bit ZC_ENABLE = 1'b1,
   localparam int SEL_W    = (N_PROF > 1) ? $clog2(N_PROF) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [SEL_W-1:0]  sel,
   input  logic              dir_up,
   input  logic              acc_msb,
   input  logic [ADDR_W-1:0] cur_start,
   input  logic [ADDR_W-1:0] cur_end,
   input  logic [MODE_W-1:0] cur_mode,
   input  logic              cur_nodwell,
   input  logic              cur_zc,
   input  logic [ADDR_W-1:0] new_start,
   output logic [ADDR_W-1:0] addr,
   output logic [SEL_W-1:0]  act,
   output logic              sw
);

   logic halted;
   logic going_up;
   logic gate_ok;

   generate
      if (ZC_ENABLE) begin : g_zc
         logic msb_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) msb_q <= 1'b0;
            else        msb_q <= acc_msb;
         end
         // The outgoing slot decides whether the change waits for an edge.
         assign gate_ok = !((cur_mode == SEQ_DIRECT) && cur_zc) || (acc_msb != msb_q);
      end else begin : g_nozc
         assign gate_ok = 1'b1;
      end
   endgenerate

   assign sw = (sel != act) && gate_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         act      <= '0;
         halted   <= 1'b0;
         going_up <= 1'b1;
      end else if (sw) begin
         act      <= sel;
         addr     <= new_start;
         halted   <= 1'b0;
         going_up <= 1'b1;
      end else if (cur_mode == SEQ_DIRECT) begin
         addr <= cur_start;
      end else if (tick) begin
         unique case (cur_mode)
            SEQ_RAMP: begin
               if (halted) begin
                  addr <= addr;
               end else if (addr != cur_end) begin
                  addr <= addr + 1'b1;
               end else if (cur_nodwell) begin
                  addr   <= cur_start;
                  halted <= 1'b1;
               end
            end
            SEQ_BIDIR: begin
               if (dir_up) begin
                  if (addr != cur_end) addr <= addr + 1'b1;
               end else begin
                  if (addr != cur_start) addr <= addr - 1'b1;
               end
            end
            SEQ_BIDIR_CONT: begin
               if (going_up) begin
                  if (addr != cur_end) begin
                     addr <= addr + 1'b1;
                  end else begin
                     going_up <= 1'b0;
                     if (addr != cur_start) addr <= addr - 1'b1;
                  end
               end else begin
                  if (addr != cur_start) begin
                     addr <= addr - 1'b1;
                  end else begin
                     going_up <= 1'b1;
                     if (addr != cur_end) addr <= addr + 1'b1;
                  end
               end
            end
            SEQ_RAMP_CONT: begin
               if (addr != cur_end) addr <= addr + 1'b1;
               else                 addr <= cur_start;
            end
            default: addr <= addr;
         endcase
      end
   end

endmodule

// File: rtl/wram_seq.sv
module wram_seq
   import wram_pkg::*;
#(
   parameter int N_PROF    = 8,
   parameter int ADDR_W    = 10,
   parameter int DATA_W    = 32,
   parameter int RATE_W    = 16,
   parameter bit ZC_ENABLE = 1'b1,
   localparam int SEL_W    = (N_PROF > 1) ? $clog2(N_PROF) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ram_we,
   input  logic [ADDR_W-1:0] ram_waddr,
   input  logic [DATA_W-1:0] ram_wdata,
   input  logic              cfg_we,
   input  logic [SEL_W-1:0]  cfg_idx,
   input  logic [RATE_W-1:0] cfg_rate,
   input  logic [ADDR_W-1:0] cfg_start,
   input  logic [ADDR_W-1:0] cfg_end,
   input  logic [2:0]        cfg_mode,
   input  logic              cfg_nodwell,
   input  logic              cfg_zc,
   input  logic [SEL_W-1:0]  prof_sel,
   input  logic              dir_up,
   input  logic              acc_msb,
   input  logic [1:0]        dest_cfg,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] word_out,
   output logic [1:0]        dest_out,
   output logic [SEL_W-1:0]  act_prof
);

   generate
      if (ADDR_W < 2 || ADDR_W > 16) begin : g_bad_addr
         $error("wram_seq: ADDR_W out of range");
      end
      if (N_PROF < 2 || (1 << SEL_W) != N_PROF) begin : g_bad_prof
         $error("wram_seq: N_PROF must be a power of two of at least 2");
      end
      if (RATE_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("wram_seq: RATE_W and DATA_W must be positive");
      end
   endgenerate

   logic [RATE_W-1:0] cur_rate;
   logic [ADDR_W-1:0] cur_start;
   logic [ADDR_W-1:0] cur_end;
   logic [MODE_W-1:0] cur_mode;
   logic              cur_nodwell;
   logic              cur_zc;
   logic [ADDR_W-1:0] new_start;
   logic              tick;
   logic              sw;
   dest_e             dest_q;

   wram_prof_bank #(.N_PROF(N_PROF), .ADDR_W(ADDR_W), .RATE_W(RATE_W)) i_bank (
      .clk(clk), .rst_n(rst_n),
      .we(cfg_we), .widx(cfg_idx), .w_rate(cfg_rate), .w_start(cfg_start),
      .w_end(cfg_end), .w_mode(cfg_mode), .w_nodwell(cfg_nodwell), .w_zc(cfg_zc),
      .act_idx(act_prof), .req_idx(prof_sel),
      .act_rate(cur_rate), .act_start(cur_start), .act_end(cur_end),
      .act_mode(cur_mode), .act_nodwell(cur_nodwell), .act_zc(cur_zc),
      .req_start(new_start)
   );

   wram_rate #(.RATE_W(RATE_W)) i_rate (
      .clk(clk), .rst_n(rst_n), .restart(sw), .rate(cur_rate), .tick(tick)
   );

   wram_addr_seq #(.N_PROF(N_PROF), .ADDR_W(ADDR_W), .ZC_ENABLE(ZC_ENABLE)) i_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .sel(prof_sel), .dir_up(dir_up),
      .acc_msb(acc_msb), .cur_start(cur_start), .cur_end(cur_end),
      .cur_mode(cur_mode), .cur_nodwell(cur_nodwell), .cur_zc(cur_zc),
      .new_start(new_start), .addr(rd_addr), .act(act_prof), .sw(sw)
   );

   wram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .waddr(ram_waddr),
      .wdata(ram_wdata), .raddr(rd_addr), .rdata(word_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dest_q <= DST_FREQ;
      else        dest_q <= dest_e'(dest_cfg);
   end

   assign dest_out = dest_q;

endmodule

// File: rtl/wram_seq_chk.sv
module wram_seq_chk #(
   parameter int N_PROF    = 8,
   parameter int ADDR_W    = 10,
   parameter bit ZC_ENABLE = 1'b1,
   localparam int SEL_W    = (N_PROF > 1) ? $clog2(N_PROF) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sw,
   input logic [2:0]        cur_mode,
   input logic              cur_nodwell,
   input logic              cur_zc,
   input logic [ADDR_W-1:0] cur_start,
   input logic [ADDR_W-1:0] cur_end,
   input logic [ADDR_W-1:0] new_start,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [SEL_W-1:0]  act_prof,
   input logic [SEL_W-1:0]  prof_sel,
   input logic [1:0]        dest_cfg,
   input logic [1:0]        dest_out,
   input logic              acc_msb
);

   logic prev_msb;
   logic have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_msb  <= 1'b0;
         have_prev <= 1'b0;
      end else begin
         prev_msb  <= acc_msb;
         have_prev <= 1'b1;
      end
   end

   p_dest_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> dest_out == $past(dest_cfg));

   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sw |=> (rd_addr == $past(new_start)) && (act_prof == $past(prof_sel)));

   p_act_only_on_switch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !sw |=> $stable(act_prof));

   p_direct_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw && cur_mode == 3'b000) |=> rd_addr == $past(cur_start));

   p_dwell_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw && cur_mode == 3'b001 && !cur_nodwell && rd_addr == cur_end)
      |=> $stable(rd_addr));

   p_zc_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ZC_ENABLE && have_prev && cur_mode == 3'b000 && cur_zc &&
       prof_sel != act_prof && acc_msb == prev_msb)
      |=> act_prof == $past(act_prof));

endmodule

bind wram_seq wram_seq_chk #(.N_PROF(N_PROF), .ADDR_W(ADDR_W), .ZC_ENABLE(ZC_ENABLE)) i_wram_seq_chk (
   .clk(clk), .rst_n(rst_n), .sw(sw), .cur_mode(cur_mode),
   .cur_nodwell(cur_nodwell), .cur_zc(cur_zc), .cur_start(cur_start),
   .cur_end(cur_end), .new_start(new_start), .rd_addr(rd_addr),
   .act_prof(act_prof), .prof_sel(prof_sel), .dest_cfg(dest_cfg),
   .dest_out(dest_out), .acc_msb(acc_msb)
);

// File: tb/test_wram_seq.sv
module test_wram_seq;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ram_we;
   logic [9:0]  ram_waddr;
   logic [31:0] ram_wdata;
   logic        cfg_we;
   logic [2:0]  cfg_idx;
   logic [15:0] cfg_rate;
   logic [9:0]  cfg_start;
   logic [9:0]  cfg_end;
   logic [2:0]  cfg_mode;
   logic        cfg_nodwell;
   logic        cfg_zc;
   logic [2:0]  prof_sel;
   logic        dir_up;
   logic        acc_msb;
   logic [1:0]  dest_cfg;
   logic [9:0]  rd_addr;
   logic [31:0] word_out;
   logic [1:0]  dest_out;
   logic [2:0]  act_prof;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wram_seq i_wram_seq (
      .clk(clk), .rst_n(rst_n), .ram_we(ram_we), .ram_waddr(ram_waddr),
      .ram_wdata(ram_wdata), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
      .cfg_rate(cfg_rate), .cfg_start(cfg_start), .cfg_end(cfg_end),
      .cfg_mode(cfg_mode), .cfg_nodwell(cfg_nodwell), .cfg_zc(cfg_zc),
      .prof_sel(prof_sel), .dir_up(dir_up), .acc_msb(acc_msb),
      .dest_cfg(dest_cfg), .rd_addr(rd_addr), .word_out(word_out),
      .dest_out(dest_out), .act_prof(act_prof)
   );

   function automatic logic [31:0] pat(int a);
      return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A_0000;
   endfunction

   // Expected address after n clocks since a reload, for modes 001/011/100.
   function automatic int exp_pos(int mode, int nd, int s, int e, int r, int n);
      int st  = n / ((r == 0) ? 1 : r);
      int len = e - s;
      int per = 2 * len;
      int k;
      case (mode)
         1: begin
            if (nd == 0) return (st >= len) ? e : s + st;
            else         return (st > len) ? s : s + st;
         end
         3: begin
            k = st % per;
            return (k <= len) ? s + k : s + per - k;
         end
         default: return s + (st % (len + 1));
      endcase
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic write_prof(int p, int s, int e, int r, int m, int nd, int zc);
      cfg_we = 1'b1; cfg_idx = 3'(p); cfg_start = 10'(s); cfg_end = 10'(e);
      cfg_rate = 16'(r); cfg_mode = 3'(m); cfg_nodwell = nd[0]; cfg_zc = zc[0];
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run_mode(string req, int p, int s, int e, int r, int m, int nd, int cycles);
      int prev;
      write_prof(p, s, e, r, m, nd, 0);
      prof_sel = 3'(p);
      @(negedge clk);
      chk("R3 reload", 32'(act_prof), 32'(p));
      prev = s;
      for (int n = 0; n <= cycles; n++) begin
         chk(req, 32'(rd_addr), 32'(exp_pos(m, nd, s, e, r, n)));
         if (n > 0) chk("R1 word follows address", word_out, pat(prev));
         prev = exp_pos(m, nd, s, e, r, n);
         @(negedge clk);
      end
   endtask

   initial begin
      rst_n = 1'b0; ram_we = 1'b0; ram_waddr = '0; ram_wdata = '0;
      cfg_we = 1'b0; cfg_idx = '0; cfg_rate = '0; cfg_start = '0; cfg_end = '0;
      cfg_mode = '0; cfg_nodwell = 1'b0; cfg_zc = 1'b0; prof_sel = '0;
      dir_up = 1'b1; acc_msb = 1'b0; dest_cfg = 2'b11;
      repeat (3) @(negedge clk);
      // R12: reset state
      chk("R12 rd_addr", 32'(rd_addr), 0);
      chk("R12 act_prof", 32'(act_prof), 0);
      chk("R12 word_out", word_out, 0);
      chk("R12 dest_out", 32'(dest_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int a = 0; a < 1024; a++) begin
         ram_we = 1'b1; ram_waddr = 10'(a); ram_wdata = pat(a);
         @(negedge clk);
      end
      ram_we = 1'b0;

      // R1/R2/R3/R5: direct switching over every address, alternating slots 1 and 2
      for (int a = 0; a < 1024; a++) begin
         int p = (a % 2 == 0) ? 1 : 2;
         dest_cfg = 2'(a);
         write_prof(p, a, a, 1, 0, 0, 0);
         prof_sel = 3'(p);
         @(negedge clk);
         chk("R3 reload address", 32'(rd_addr), 32'(a));
         chk("R3 active profile", 32'(act_prof), 32'(p));
         @(negedge clk);
         chk("R1 read data", word_out, pat(a));
         chk("R2 destination code", 32'(dest_out), 32'(a % 4));
         chk("R5 direct holds start", 32'(rd_addr), 32'(a));
      end

      run_mode("R6/R4 ramp-up dwell", 3, 100, 105, 3, 1, 0, 30);
      run_mode("R7/R4 ramp-up no-dwell", 4, 200, 203, 2, 1, 1, 20);
      run_mode("R9 bidirectional continuous", 6, 400, 403, 1, 3, 0, 20);
      run_mode("R10/R4 ramp-up continuous", 7, 500, 502, 4, 4, 0, 30);

      // R8: bidirectional with rate 0 (acts as 1)
      dir_up = 1'b1;
      write_prof(5, 300, 304, 0, 2, 0, 0);
      prof_sel = 3'd5;
      @(negedge clk);
      for (int n = 0; n <= 7; n++) begin
         chk("R8/R4 bidirectional up", 32'(rd_addr), 32'((300 + n > 304) ? 304 : 300 + n));
         if (n < 7) @(negedge clk);
      end
      dir_up = 1'b0;
      for (int m = 1; m <= 7; m++) begin
         @(negedge clk);
         chk("R8 bidirectional down", 32'(rd_addr), 32'((304 - m < 300) ? 300 : 304 - m));
      end

      // R11: zero-crossing gating, rising then falling accumulator MSB
      write_prof(0, 600, 600, 1, 0, 0, 1);
      write_prof(1, 610, 610, 1, 0, 0, 0);
      write_prof(2, 620, 620, 1, 0, 0, 1);
      prof_sel = 3'd0;
      @(negedge clk);
      chk("R11 enter gated slot", 32'(rd_addr), 600);
      prof_sel = 3'd1;
      repeat (4) @(negedge clk);
      chk("R11 change held back", 32'(act_prof), 0);
      chk("R11 address kept", 32'(rd_addr), 600);
      acc_msb = 1'b1;
      @(negedge clk);
      chk("R11 change on rising MSB", 32'(act_prof), 1);
      chk("R11 reload after edge", 32'(rd_addr), 610);
      prof_sel = 3'd2;
      @(negedge clk);
      chk("R11 ungated slot switches at once", 32'(act_prof), 2);
      prof_sel = 3'd0;
      repeat (3) @(negedge clk);
      chk("R11 change held back again", 32'(act_prof), 2);
      acc_msb = 1'b0;
      @(negedge clk);
      chk("R11 change on falling MSB", 32'(act_prof), 0);
      chk("R11 reload to slot 0", 32'(rd_addr), 600);
      @(negedge clk);
      chk("R1 word in gated slot", word_out, pat(600));

      if (!done) begin
         done = 1'b1;
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         done = 1'b1;
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule